// File: doc/BRIEF.md
# Bridge Flush-Before-Read Ordering Controller

This block sits between the processor-side slave port and the PCI-side slave port of a two-bus bridge. Each direction has its own posted-write FIFO. The block tracks how many writes sit in each FIFO from push and pop strobes. For every read or register access that arrives on either port, it decides whether the requester is held with wait states, told to retry, or allowed to proceed. The aim is that posted writes reach their target before any read data is returned.

A processor transaction is announced by a one-cycle start strobe. Its read/write and register-target flags are trusted only after a fixed settle interval. During that interval the processor port is held. Once the interval has passed, the block gives one of three answers:

- A processor read with flushing enabled is retried while any PCI-originated write is still waiting to complete on the processor bus.
- A processor read with flushing enabled is held while the PCI-bound FIFO still has data. A retry takes priority over this hold.
- A processor access to the bridge's own registers is held until the PCI-bound FIFO is empty.

On the PCI side, requests are levels held by the master:

- A read with flushing enabled is held while the processor-bound FIFO has data.
- A configuration cycle to the bridge's internal registers is held until both FIFOs are empty. If a read and a configuration request are both present, the configuration rules apply.

Top module: `fbr_order_ctrl`

## Requirements
- R1: With a direction's flush enable low, a read from that side proceeds (go) regardless of FIFO occupancy: processor read after settle gives cpu_go, PCI read gives pci_go.
- R2: With cpu_flush_en high, a processor read with no PCI-originated writes pending is held (cpu_wait) while the PCI-bound FIFO holds any entry. It gets cpu_go in the first cycle after that FIFO reaches zero.
- R3: With cpu_flush_en high, a processor read is retried (cpu_retry for one cycle) whenever the processor-bound FIFO holds an entry. This holds even when the PCI-bound FIFO is also non-empty, so retry wins over wait.
- R4: In the SETTLE_CYC cycles after cpu_start, cpu_wait is high and no go or retry is given; the decision appears in the following cycle.
- R5: With pci_flush_en high, a PCI read gets pci_wait while the processor-bound FIFO holds any entry, and pci_go otherwise.
- R6: A PCI configuration request gets pci_wait while either FIFO holds any entry, independent of both enables, and pci_go when both are empty.
- R7: A processor register access (cpu_is_reg high) is held while the PCI-bound FIFO holds any entry, independent of cpu_flush_en and of the processor-bound FIFO; it never retries.
- R8: A push and a pop on the same FIFO in one cycle leave its count unchanged.
- R9: Each port's outputs are one-hot or all low. go and retry last one cycle and end the processor transaction. After reset, both counts are zero and all processor outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_flush_en | input | 1 | Flush enable for processor-originated reads |
| pci_flush_en | input | 1 | Flush enable for PCI-originated reads |
| cpu_start | input | 1 | One-cycle processor transfer-start strobe |
| cpu_is_read | input | 1 | Processor transaction is a read (valid after settle) |
| cpu_is_reg | input | 1 | Processor transaction targets bridge registers (valid after settle) |
| pci_rd_req | input | 1 | PCI read request, held until go |
| pci_cfg_req | input | 1 | PCI configuration request to internal registers, held until go |
| to_pci_push | input | 1 | Processor write posted into PCI-bound FIFO |
| to_pci_pop | input | 1 | PCI-bound write completed on PCI |
| to_cpu_push | input | 1 | PCI slave accepted a posted write |
| to_cpu_pop | input | 1 | Processor-bound write completed on processor bus |
| cpu_wait | output | 1 | Hold the processor with wait states |
| cpu_retry | output | 1 | Retry the processor transaction |
| cpu_go | output | 1 | Processor transaction may proceed |
| pci_wait | output | 1 | Hold the PCI master with wait states |
| pci_go | output | 1 | PCI transaction may proceed |

## Verification
The retry and the hold of a processor read can both be due in the same decision cycle. This happens when both posted-write FIFOs are non-empty with the processor flush enable set. The bench fills both FIFOs before issuing the read and expects a single-cycle retry with no wait. Push and pop on the same FIFO can also coincide. The bench strobes both while a register access is held and judges, from the ports, that the hold persists until exactly one further pop releases it.

// File: rtl/fbr_pkg.sv
`timescale 1ns/1ps
package fbr_pkg;

    // Processor-side transaction phase
    typedef enum logic [1:0] {
        PH_IDLE   = 2'd0,
        PH_SETTLE = 2'd1,
        PH_DECIDE = 2'd2
    } phase_e;

    // Direction index for the posted-write counters
    localparam int DIR_TO_PCI = 0;
    localparam int DIR_TO_CPU = 1;
    localparam int NUM_DIR    = 2;

endpackage

// File: rtl/fbr_occ_counter.sv
`timescale 1ns/1ps
module fbr_occ_counter #(
    parameter int DEPTH = 4,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push,
    input  logic          pop,
    output logic          empty,
    output logic [CW-1:0] count
);

    logic [CW-1:0] count_d, count_q;

    always_comb begin
        count_d = count_q;
        if (push && !pop)      count_d = count_q + CW'(1);
        else if (pop && !push) count_d = count_q - CW'(1);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) count_q <= '0;
        else        count_q <= count_d;
    end

    assign empty = (count_q == '0);
    assign count = count_q;

    // R8: coincident push and pop keep the occupancy
    p_same_cycle_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (push && pop) |=> $stable(count_q))
        else $error("count moved on push+pop");

    p_no_overflow_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (push && !pop) |-> (count_q != CW'(DEPTH)))
        else $error("push into full FIFO");

    p_no_underflow_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (pop && !push) |-> (count_q != '0))
        else $error("pop from empty FIFO");

endmodule

// File: rtl/fbr_cpu_arb.sv
`timescale 1ns/1ps
module fbr_cpu_arb
    import fbr_pkg::*;
#(
    parameter int SETTLE_CYC = 3,
    localparam int SW = (SETTLE_CYC > 1) ? $clog2(SETTLE_CYC) : 1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic flush_en,
    input  logic start,
    input  logic is_read,
    input  logic is_reg,
    input  logic to_pci_empty,
    input  logic to_cpu_empty,
    output logic hold,
    output logic retry,
    output logic go
);

    typedef struct packed {
        phase_e        phase;
        logic [SW-1:0] settle;
    } cpu_st_t;

    cpu_st_t st_d, st_q;
    logic    dec_retry, dec_hold;

    // Decision terms, meaningful only in the decide phase
    always_comb begin
        dec_retry = 1'b0;
        dec_hold  = 1'b0;
        if (is_reg) begin
            dec_hold = !to_pci_empty;
        end else if (is_read && flush_en) begin
            dec_retry = !to_cpu_empty;
            dec_hold  = !to_pci_empty && to_cpu_empty;
        end
    end

    always_comb begin
        st_d = st_q;
        case (st_q.phase)
            PH_IDLE: if (start) begin
                st_d.phase  = PH_SETTLE;
                st_d.settle = SW'(SETTLE_CYC - 1);
            end
            PH_SETTLE: begin
                if (st_q.settle == '0) st_d.phase  = PH_DECIDE;
                else                   st_d.settle = st_q.settle - SW'(1);
            end
            PH_DECIDE: if (!dec_hold) st_d.phase = PH_IDLE;
            default: st_d.phase = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.phase  <= PH_IDLE;
            st_q.settle <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign hold  = (st_q.phase == PH_SETTLE) || ((st_q.phase == PH_DECIDE) && dec_hold);
    assign retry = (st_q.phase == PH_DECIDE) && dec_retry;
    assign go    = (st_q.phase == PH_DECIDE) && !dec_retry && !dec_hold;

    p_settle_wait_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.phase == PH_IDLE && start) |=> (hold && !go && !retry))
        else $error("decision before decode settled");

    p_retry_prio_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.phase == PH_DECIDE && !is_reg && is_read && flush_en && !to_cpu_empty)
        |-> (retry && !hold))
        else $error("retry not given priority");

    p_reg_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.phase == PH_DECIDE && is_reg && !to_pci_empty) |-> (hold && !retry))
        else $error("register access not held");

    p_off_go_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.phase == PH_DECIDE && !is_reg && !flush_en) |-> go)
        else $error("disabled flush still blocked");

    p_onehot_cpu_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({hold, retry, go}))
        else $error("processor outputs not one-hot");

    p_end_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (go || retry) |=> (!go && !retry))
        else $error("go/retry longer than one cycle");

endmodule

// File: rtl/fbr_pci_arb.sv
`timescale 1ns/1ps
module fbr_pci_arb (
    input  logic clk,
    input  logic rst_n,
    input  logic flush_en,
    input  logic rd_req,
    input  logic cfg_req,
    input  logic to_pci_empty,
    input  logic to_cpu_empty,
    output logic hold,
    output logic go
);

    logic busy_any, hold_d;

    always_comb begin
        busy_any = !to_pci_empty || !to_cpu_empty;
        hold_d   = 1'b0;
        if (cfg_req)     hold_d = busy_any;
        else if (rd_req) hold_d = flush_en && !to_cpu_empty;
    end

    assign hold = hold_d;
    assign go   = (cfg_req || rd_req) && !hold_d;

    p_cfg_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_req && (!to_pci_empty || !to_cpu_empty)) |-> (hold && !go))
        else $error("config cycle not deferred");

    p_rd_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req && !cfg_req && flush_en && !to_cpu_empty) |-> hold)
        else $error("PCI read not held");

    p_onehot_pci_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({hold, go}))
        else $error("PCI outputs not one-hot");

endmodule

// File: rtl/fbr_order_ctrl.sv
`timescale 1ns/1ps
module fbr_order_ctrl
    import fbr_pkg::*;
#(
    parameter int DEPTH      = 4,
    parameter int SETTLE_CYC = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cpu_flush_en,
    input  logic pci_flush_en,
    input  logic cpu_start,
    input  logic cpu_is_read,
    input  logic cpu_is_reg,
    input  logic pci_rd_req,
    input  logic pci_cfg_req,
    input  logic to_pci_push,
    input  logic to_pci_pop,
    input  logic to_cpu_push,
    input  logic to_cpu_pop,
    output logic cpu_wait,
    output logic cpu_retry,
    output logic cpu_go,
    output logic pci_wait,
    output logic pci_go
);

    localparam int CW = $clog2(DEPTH + 1);

    logic [NUM_DIR-1:0] push_v, pop_v, empty_v;
    logic [CW-1:0]      count_v [NUM_DIR];

    assign push_v[DIR_TO_PCI] = to_pci_push;
    assign pop_v [DIR_TO_PCI] = to_pci_pop;
    assign push_v[DIR_TO_CPU] = to_cpu_push;
    assign pop_v [DIR_TO_CPU] = to_cpu_pop;

    for (genvar g = 0; g < NUM_DIR; g++) begin : g_dir
        fbr_occ_counter #(.DEPTH(DEPTH)) u_cnt (
            .clk   (clk),
            .rst_n (rst_n),
            .push  (push_v[g]),
            .pop   (pop_v[g]),
            .empty (empty_v[g]),
            .count (count_v[g])
        );
    end

    fbr_cpu_arb #(.SETTLE_CYC(SETTLE_CYC)) u_cpu (
        .clk          (clk),
        .rst_n        (rst_n),
        .flush_en     (cpu_flush_en),
        .start        (cpu_start),
        .is_read      (cpu_is_read),
        .is_reg       (cpu_is_reg),
        .to_pci_empty (empty_v[DIR_TO_PCI]),
        .to_cpu_empty (empty_v[DIR_TO_CPU]),
        .hold         (cpu_wait),
        .retry        (cpu_retry),
        .go           (cpu_go)
    );

    fbr_pci_arb u_pci (
        .clk          (clk),
        .rst_n        (rst_n),
        .flush_en     (pci_flush_en),
        .rd_req       (pci_rd_req),
        .cfg_req      (pci_cfg_req),
        .to_pci_empty (empty_v[DIR_TO_PCI]),
        .to_cpu_empty (empty_v[DIR_TO_CPU]),
        .hold         (pci_wait),
        .go           (pci_go)
    );

    // R2: a flushing processor read never proceeds over a non-empty PCI-bound FIFO
    p_rd_drain_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_go && cpu_flush_en && cpu_is_read && !cpu_is_reg) |-> (count_v[DIR_TO_PCI] == '0))
        else $error("read passed posted writes");

endmodule

// File: tb/fbr_order_ctrl_test.sv
`timescale 1ns/1ps
module fbr_order_ctrl_test;

    localparam int SETTLE = 3;
    localparam int NVEC   = 11;
    // cpu decision codes used by the bench
    localparam logic [1:0] C_GO = 2'd0, C_WT = 2'd1, C_RT = 2'd2;

    // [11] cpu_en [10] pci_en [9:8] to_pci fill [7:6] to_cpu fill
    // [5] read [4] reg [3:2] cpu code [1] pci read waits [0] cfg waits
    localparam logic [11:0] VEC [NVEC] = '{
        {1'b0,1'b0,2'd2,2'd1,1'b1,1'b0,C_GO,1'b0,1'b1},
        {1'b1,1'b0,2'd2,2'd0,1'b1,1'b0,C_WT,1'b0,1'b1},
        {1'b1,1'b0,2'd0,2'd1,1'b1,1'b0,C_RT,1'b0,1'b1},
        {1'b1,1'b1,2'd2,2'd2,1'b1,1'b0,C_RT,1'b1,1'b1},
        {1'b0,1'b1,2'd0,2'd1,1'b1,1'b0,C_GO,1'b1,1'b1},
        {1'b1,1'b1,2'd0,2'd0,1'b1,1'b0,C_GO,1'b0,1'b0},
        {1'b0,1'b0,2'd1,2'd0,1'b0,1'b1,C_WT,1'b0,1'b1},
        {1'b0,1'b0,2'd0,2'd2,1'b0,1'b1,C_GO,1'b0,1'b1},
        {1'b1,1'b1,2'd0,2'd1,1'b0,1'b0,C_GO,1'b1,1'b1},
        {1'b0,1'b1,2'd3,2'd0,1'b1,1'b0,C_GO,1'b0,1'b1},
        {1'b1,1'b0,2'd3,2'd3,1'b1,1'b0,C_RT,1'b0,1'b1}
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cpu_flush_en = 1'b0, pci_flush_en = 1'b0;
    logic cpu_start = 1'b0, cpu_is_read = 1'b0, cpu_is_reg = 1'b0;
    logic pci_rd_req = 1'b0, pci_cfg_req = 1'b0;
    logic to_pci_push = 1'b0, to_pci_pop = 1'b0, to_cpu_push = 1'b0, to_cpu_pop = 1'b0;
    logic cpu_wait, cpu_retry, cpu_go, pci_wait, pci_go;

    int checks = 0, failures = 0;
    int n_tx = 0, n_rx = 0;
    bit done = 0;

    always #10 clk = ~clk;

    fbr_order_ctrl #(.DEPTH(4), .SETTLE_CYC(SETTLE)) uut (
        .clk(clk), .rst_n(rst_n),
        .cpu_flush_en(cpu_flush_en), .pci_flush_en(pci_flush_en),
        .cpu_start(cpu_start), .cpu_is_read(cpu_is_read), .cpu_is_reg(cpu_is_reg),
        .pci_rd_req(pci_rd_req), .pci_cfg_req(pci_cfg_req),
        .to_pci_push(to_pci_push), .to_pci_pop(to_pci_pop),
        .to_cpu_push(to_cpu_push), .to_cpu_pop(to_cpu_pop),
        .cpu_wait(cpu_wait), .cpu_retry(cpu_retry), .cpu_go(cpu_go),
        .pci_wait(pci_wait), .pci_go(pci_go)
    );

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic int cpu_code();
        if (cpu_retry) return 2;
        if (cpu_wait)  return 1;
        if (cpu_go)    return 0;
        return 3;
    endfunction

    task automatic fill(input int tx, input int rx);
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            to_pci_push = (i < tx);
            to_cpu_push = (i < rx);
        end
        @(negedge clk);
        to_pci_push = 1'b0;
        to_cpu_push = 1'b0;
        n_tx += tx;
        n_rx += rx;
    endtask

    task automatic drain();
        while (n_tx > 0 || n_rx > 0) begin
            @(negedge clk);
            to_pci_pop = (n_tx > 0);
            to_cpu_pop = (n_rx > 0);
            if (n_tx > 0) n_tx--;
            if (n_rx > 0) n_rx--;
        end
        @(negedge clk);
        to_pci_pop = 1'b0;
        to_cpu_pop = 1'b0;
        repeat (2) @(negedge clk);
    endtask

    // Start a processor transaction; returns at the negedge of the decide cycle
    task automatic cpu_txn(input logic rd, input logic rg);
        @(negedge clk);
        cpu_start   = 1'b1;
        cpu_is_read = rd;
        cpu_is_reg  = rg;
        @(negedge clk);
        cpu_start = 1'b0;
        for (int s = 0; s < SETTLE; s++) begin
            check($sformatf("R4 settle cycle %0d wait", s), {31'd0, cpu_wait}, 1);
            check($sformatf("R4 settle cycle %0d no decision", s), {31'd0, cpu_go | cpu_retry}, 0);
            @(negedge clk);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R9 reset state
        check("R9 reset cpu outputs", {29'd0, cpu_wait, cpu_retry, cpu_go}, 0);
        pci_cfg_req = 1'b1; #1;
        check("R9 reset counts empty (cfg go)", {31'd0, pci_go}, 1);
        pci_cfg_req = 1'b0;

        // Vector table
        for (int v = 0; v < NVEC; v++) begin
            logic [11:0] e;
            e = VEC[v];
            fill(int'(e[9:8]), int'(e[7:6]));
            cpu_flush_en = e[11];
            pci_flush_en = e[10];
            pci_rd_req = 1'b1; #1;
            check($sformatf("R5/R1 vec%0d pci read wait", v), {31'd0, pci_wait}, int'(e[1]));
            check($sformatf("R9 vec%0d pci read go", v), {31'd0, pci_go}, int'(!e[1]));
            pci_rd_req = 1'b0; pci_cfg_req = 1'b1; #1;
            check($sformatf("R6 vec%0d cfg wait", v), {31'd0, pci_wait}, int'(e[0]));
            pci_cfg_req = 1'b0;
            cpu_txn(e[5], e[4]);
            check($sformatf("R1/R2/R3/R7 vec%0d cpu decision", v), cpu_code(), int'(e[3:2]));
            drain();
            check($sformatf("R9 vec%0d idle after", v), {29'd0, cpu_wait, cpu_retry, cpu_go}, 0);
        end

        // R2: progressive drain releases the read only at zero
        cpu_flush_en = 1'b1; pci_flush_en = 1'b0;
        fill(2, 0);
        cpu_txn(1'b1, 1'b0);
        check("R2 held with two entries", cpu_code(), 1);
        to_pci_pop = 1'b1; @(negedge clk); to_pci_pop = 1'b0; n_tx--;
        check("R2 held with one entry", cpu_code(), 1);
        to_pci_pop = 1'b1; @(negedge clk); to_pci_pop = 1'b0; n_tx--;
        check("R2 go once empty", cpu_code(), 0);
        @(negedge clk);
        check("R9 go lasts one cycle", {31'd0, cpu_go}, 0);

        // R3: retry lasts one cycle, transaction ends
        fill(0, 1);
        cpu_txn(1'b1, 1'b0);
        check("R3 retry on pending inbound write", cpu_code(), 2);
        @(negedge clk);
        check("R9 retry ends transaction", {29'd0, cpu_wait, cpu_retry, cpu_go}, 0);
        drain();

        // R8: same-cycle push/pop on PCI-bound FIFO under a held register access
        cpu_flush_en = 1'b0;
        fill(1, 0);
        cpu_txn(1'b0, 1'b1);
        check("R7 register access held", cpu_code(), 1);
        to_pci_push = 1'b1; to_pci_pop = 1'b1;
        @(negedge clk);
        to_pci_push = 1'b0; to_pci_pop = 1'b0;
        check("R8 push+pop keeps count (still held)", cpu_code(), 1);
        to_pci_pop = 1'b1; @(negedge clk); to_pci_pop = 1'b0; n_tx--;
        check("R8 one pop releases", cpu_code(), 0);
        @(negedge clk);

        // R8: same-cycle push/pop on processor-bound FIFO keeps PCI read held
        pci_flush_en = 1'b1;
        fill(0, 1);
        to_cpu_push = 1'b1; to_cpu_pop = 1'b1;
        @(negedge clk);
        to_cpu_push = 1'b0; to_cpu_pop = 1'b0;
        pci_rd_req = 1'b1; #1;
        check("R8 inbound push+pop keeps count", {31'd0, pci_wait}, 1);
        pci_rd_req = 1'b0;
        drain();

        // R9: reset mid-stream clears occupancy
        fill(2, 2);
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1; n_tx = 0; n_rx = 0;
        pci_cfg_req = 1'b1; #1;
        check("R9 reset clears counts", {31'd0, pci_go}, 1);
        pci_cfg_req = 1'b0;
        check("R9 reset cpu outputs low", {29'd0, cpu_wait, cpu_retry, cpu_go}, 0);

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule